// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block moves a 32-byte line from a second-level cache into a first-level cache over a 64-bit backside path. A line therefore arrives as four 8-byte beats. The lower level answers each request with a fixed burst: the first beat comes four cycles after the request and each remaining beat one cycle after the one before it. The requester presents a line address on a valid/ready miss port. The controller places each new miss in a miss-status entry and sends one request per line to the lower level, tagged with the entry number. It writes every returning beat into the L1 data array as a separate 8-byte word. After the last word has been written, it raises a one-cycle pulse that marks the line valid.

The controller is non-blocking. Up to four fills can be in progress at once, and new misses are accepted while earlier bursts are still streaming in. A miss to a line that already has an entry merges into that entry: it sends no second request and produces no second completion. When all four entries are busy and the miss matches none of them, the port holds ready low until an entry is released.

Each entry runs a four-state machine: FREE, SEND, AWAIT and DONE.
- FREE goes to SEND on allocation.
- SEND goes to AWAIT when the request is issued.
- AWAIT goes to DONE on the fourth beat.
- DONE returns to FREE after one cycle, in the same edge that produces the valid pulse.

Top module: `fill_burst_ctrl`

## Requirements
- R1: After reset, miss_ready is 1 and l2_req_valid, l1_wr_en and l1_line_valid are all 0.
- R2: A miss accepted without a merge produces l2_req_valid in the next cycle, carrying the same line address and the tag of the entry it was given.
- R3: A beat presented with a tag is written one cycle later with l1_wr_en high. The write carries the tagged entry's line address, the beat data and a word index. The word index counts 0, 1, 2, 3 in arrival order, and word 0 holds line bytes 0 to 7.
- R4: l1_line_valid pulses for one cycle, exactly once per fill, in the cycle right after the write of word 3 of that line, with l1_valid_line equal to that line.
- R5: A miss whose line matches a busy entry is accepted at once. It causes no request to the lower level and no extra valid pulse.
- R6: With four entries busy, a miss to an untracked line sees miss_ready low. It is accepted in the first cycle after an entry returns to FREE.
- R7: A miss to a new line is accepted while other fills are still outstanding, as long as a free entry exists.
- R8: Valid pulses occur in the order in which the bursts completed, and there is at most one pulse per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | 27 | Line address of the miss |
| miss_ready | output | 1 | Miss accepted this cycle when high |
| l2_req_valid | output | 1 | Fill request to the lower level |
| l2_req_line | output | 27 | Line address being requested |
| l2_req_tag | output | 2 | Entry number returned with each beat |
| l2_beat_valid | input | 1 | A data beat is present |
| l2_beat_tag | input | 2 | Entry the beat belongs to |
| l2_beat_data | input | 64 | Eight bytes of the line |
| l1_wr_en | output | 1 | Write one word into the L1 data array |
| l1_wr_line | output | 27 | Line address of the word write |
| l1_wr_word | output | 2 | Word index within the line |
| l1_wr_data | output | 64 | Word being written |
| l1_line_valid | output | 1 | Mark the line valid (one-cycle pulse) |
| l1_valid_line | output | 27 | Line address being marked valid |

## Verification
The entry-level assertions assume the lower level behaves in three ways:
- It sends beats only for a tag it was given a request for.
- It sends exactly four beats for each such tag.
- It keeps the beats of one tag in order.

The bench responder satisfies all three. It serves queued requests strictly one burst at a time, in request order, on the 4-1-1-1 schedule, and it ends each burst after the fourth beat.

The miss driver holds miss_valid and miss_line steady until it sees ready at an edge. It draws lines from a small pool, so that merges, merges into a finishing entry and full-occupancy stalls all occur.

// File: rtl/fill_ctrl_pkg.sv
package fill_ctrl_pkg;

    typedef enum logic [1:0] {
        MS_FREE  = 2'd0,
        MS_SEND  = 2'd1,
        MS_AWAIT = 2'd2,
        MS_DONE  = 2'd3
    } mshr_state_e;

endpackage

// File: rtl/fill_mshr_entry.sv
module fill_mshr_entry
    import fill_ctrl_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int WORDS  = 4,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [LINE_W-1:0] alloc_line_i,
    input  logic              grant_i,
    input  logic              beat_i,
    input  logic [LINE_W-1:0] probe_line_i,
    output mshr_state_e       state_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CNT_W-1:0]  word_o,
    output logic              match_o
);

    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS - 1);

    mshr_state_e       state_q;
    mshr_state_e       state_d;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_FREE:  if (alloc_i) state_d = MS_SEND;
            MS_SEND:  if (grant_i) state_d = MS_AWAIT;
            MS_AWAIT: if (beat_i && (cnt_q == LAST_WORD)) state_d = MS_DONE;
            MS_DONE:  state_d = MS_FREE;
            default:  state_d = MS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            cnt_q  <= '0;
        end else if (alloc_i && (state_q == MS_FREE)) begin
            line_q <= alloc_line_i;
            cnt_q  <= '0;
        end else if (beat_i && (state_q == MS_AWAIT)) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_o = state_q;
        line_o  = line_q;
        word_o  = cnt_q;
        match_o = (state_q != MS_FREE) && (line_q == probe_line_i);
    end

    // Allocation only ever targets a free entry (R6).
    assert_alloc_into_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (state_q == MS_FREE));

    // Issue grant only reaches an entry waiting to send (R2).
    assert_grant_in_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> (state_q == MS_SEND));

    // Beats arrive only for an entry whose request has gone out (R3).
    assert_beat_when_awaiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i |-> (state_q == MS_AWAIT));

    // Once DONE, the entry is released in the next cycle (R6).
    assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_DONE) |=> (state_q == MS_FREE));

endmodule

// File: rtl/fill_prio_pick.sv
module fill_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                gnt_o[i] = 1'b1;
                idx_o    = IDX_W'(i);
                found    = 1'b1;
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/fill_l1_writer.sv
module fill_l1_writer #(
    parameter int N      = 4,
    parameter int TAG_W  = 2,
    parameter int LINE_W = 27,
    parameter int CNT_W  = 2,
    parameter int BEAT_W = 64,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid_i,
    input  logic [TAG_W-1:0]  beat_tag_i,
    input  logic [BEAT_W-1:0] beat_data_i,
    input  logic [LINE_W-1:0] line_arr_i [N],
    input  logic [CNT_W-1:0]  word_arr_i [N],
    input  logic [N-1:0]      done_vec_i,
    output logic              wr_en_o,
    output logic [LINE_W-1:0] wr_line_o,
    output logic [CNT_W-1:0]  wr_word_o,
    output logic [BEAT_W-1:0] wr_data_o,
    output logic              valid_o,
    output logic [LINE_W-1:0] valid_line_o
);

    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS - 1);

    logic [LINE_W-1:0] done_line;

    always_comb begin
        done_line = '0;
        for (int i = 0; i < N; i++) begin
            if (done_vec_i[i]) done_line = line_arr_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o      <= 1'b0;
            wr_line_o    <= '0;
            wr_word_o    <= '0;
            wr_data_o    <= '0;
            valid_o      <= 1'b0;
            valid_line_o <= '0;
        end else begin
            wr_en_o <= beat_valid_i;
            if (beat_valid_i) begin
                wr_line_o <= line_arr_i[beat_tag_i];
                wr_word_o <= word_arr_i[beat_tag_i];
                wr_data_o <= beat_data_i;
            end
            valid_o <= |done_vec_i;
            if (|done_vec_i) valid_line_o <= done_line;
        end
    end

    // Every beat becomes a word write one cycle later (R3).
    assert_write_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_i |=> wr_en_o);

    // The valid pulse follows the write of the last word of the same line (R4).
    assert_valid_after_last_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(wr_en_o) && ($past(wr_word_o) == LAST_WORD)
                     && ($past(wr_line_o) == valid_line_o)));

endmodule

// File: rtl/fill_burst_ctrl.sv
module fill_burst_ctrl
    import fill_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 64,
    parameter int N_ENTRIES  = 4,
    parameter int LINE_W     = ADDR_W - $clog2(LINE_BYTES),
    parameter int WORDS      = (LINE_BYTES * 8) / BEAT_W,
    parameter int CNT_W      = (WORDS > 1) ? $clog2(WORDS) : 1,
    parameter int TAG_W      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    output logic              miss_ready,
    output logic              l2_req_valid,
    output logic [LINE_W-1:0] l2_req_line,
    output logic [TAG_W-1:0]  l2_req_tag,
    input  logic              l2_beat_valid,
    input  logic [TAG_W-1:0]  l2_beat_tag,
    input  logic [BEAT_W-1:0] l2_beat_data,
    output logic              l1_wr_en,
    output logic [LINE_W-1:0] l1_wr_line,
    output logic [CNT_W-1:0]  l1_wr_word,
    output logic [BEAT_W-1:0] l1_wr_data,
    output logic              l1_line_valid,
    output logic [LINE_W-1:0] l1_valid_line
);

    mshr_state_e       ent_state [N_ENTRIES];
    logic [LINE_W-1:0] ent_line  [N_ENTRIES];
    logic [CNT_W-1:0]  ent_word  [N_ENTRIES];
    logic [N_ENTRIES-1:0] ent_match;
    logic [N_ENTRIES-1:0] ent_free;
    logic [N_ENTRIES-1:0] ent_send;
    logic [N_ENTRIES-1:0] ent_done;
    logic [N_ENTRIES-1:0] ent_beat;
    logic [N_ENTRIES-1:0] ent_alloc;
    logic [N_ENTRIES-1:0] free_pick;
    logic [N_ENTRIES-1:0] send_gnt;
    logic [TAG_W-1:0]     free_idx;
    logic [TAG_W-1:0]     send_idx;
    logic                 free_any;
    logic                 send_any;
    logic                 merge_hit;
    logic                 accept_new;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        fill_mshr_entry #(
            .LINE_W (LINE_W),
            .WORDS  (WORDS),
            .CNT_W  (CNT_W)
        ) entry_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (ent_alloc[g]),
            .alloc_line_i (miss_line),
            .grant_i      (send_gnt[g]),
            .beat_i       (ent_beat[g]),
            .probe_line_i (miss_line),
            .state_o      (ent_state[g]),
            .line_o       (ent_line[g]),
            .word_o       (ent_word[g]),
            .match_o      (ent_match[g])
        );

        always_comb begin
            ent_free[g]  = (ent_state[g] == MS_FREE);
            ent_send[g]  = (ent_state[g] == MS_SEND);
            ent_done[g]  = (ent_state[g] == MS_DONE);
            ent_beat[g]  = l2_beat_valid && (l2_beat_tag == TAG_W'(g));
            ent_alloc[g] = accept_new && free_pick[g];
        end
    end

    fill_prio_pick #(.N(N_ENTRIES), .IDX_W(TAG_W)) alloc_pick_i (
        .req_i (ent_free),
        .gnt_o (free_pick),
        .idx_o (free_idx),
        .any_o (free_any)
    );

    fill_prio_pick #(.N(N_ENTRIES), .IDX_W(TAG_W)) issue_pick_i (
        .req_i (ent_send),
        .gnt_o (send_gnt),
        .idx_o (send_idx),
        .any_o (send_any)
    );

    always_comb begin
        merge_hit    = |ent_match;
        miss_ready   = merge_hit || free_any;
        accept_new   = miss_valid && free_any && !merge_hit;
        l2_req_valid = send_any;
        l2_req_line  = ent_line[send_idx];
        l2_req_tag   = send_idx;
    end

    fill_l1_writer #(
        .N      (N_ENTRIES),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .CNT_W  (CNT_W),
        .BEAT_W (BEAT_W),
        .WORDS  (WORDS)
    ) writer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid_i (l2_beat_valid),
        .beat_tag_i   (l2_beat_tag),
        .beat_data_i  (l2_beat_data),
        .line_arr_i   (ent_line),
        .word_arr_i   (ent_word),
        .done_vec_i   (ent_done),
        .wr_en_o      (l1_wr_en),
        .wr_line_o    (l1_wr_line),
        .wr_word_o    (l1_wr_word),
        .wr_data_o    (l1_wr_data),
        .valid_o      (l1_line_valid),
        .valid_line_o (l1_valid_line)
    );

    // A new allocation issues its request in the next cycle (R2).
    assert_req_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_new |=> (l2_req_valid && (l2_req_line == $past(miss_line))));

    // A merged miss never causes a request (R5).
    assert_merge_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && merge_hit) |=> !l2_req_valid);

    // Not ready only when no entry is free and no entry matches (R6).
    assert_backpressure_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> ($countones(ent_free) == 0));

    // At most one entry completes per cycle (R8).
    assert_single_completion_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_done));

endmodule

// File: tb/fill_burst_ctrl_tb_top.sv
module fill_burst_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 27;
    localparam int BEAT_W = 64;
    localparam int TAG_W  = 2;
    localparam int CNT_W  = 2;
    localparam int N_ENT  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [LINE_W-1:0] miss_line = '0;
    logic              miss_ready;
    logic              l2_req_valid;
    logic [LINE_W-1:0] l2_req_line;
    logic [TAG_W-1:0]  l2_req_tag;
    logic              l2_beat_valid = 1'b0;
    logic [TAG_W-1:0]  l2_beat_tag = '0;
    logic [BEAT_W-1:0] l2_beat_data = '0;
    logic              l1_wr_en;
    logic [LINE_W-1:0] l1_wr_line;
    logic [CNT_W-1:0]  l1_wr_word;
    logic [BEAT_W-1:0] l1_wr_data;
    logic              l1_line_valid;
    logic [LINE_W-1:0] l1_valid_line;

    fill_burst_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_line     (miss_line),
        .miss_ready    (miss_ready),
        .l2_req_valid  (l2_req_valid),
        .l2_req_line   (l2_req_line),
        .l2_req_tag    (l2_req_tag),
        .l2_beat_valid (l2_beat_valid),
        .l2_beat_tag   (l2_beat_tag),
        .l2_beat_data  (l2_beat_data),
        .l1_wr_en      (l1_wr_en),
        .l1_wr_line    (l1_wr_line),
        .l1_wr_word    (l1_wr_word),
        .l1_wr_data    (l1_wr_data),
        .l1_line_valid (l1_line_valid),
        .l1_valid_line (l1_valid_line)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // scoreboard state
    int                outst     [logic [LINE_W-1:0]];
    int                next_word [logic [LINE_W-1:0]];
    logic [LINE_W-1:0] tag_line  [N_ENT];
    logic [LINE_W-1:0] exp_done  [$];
    bit                exp_req_pending = 1'b0;
    logic [LINE_W-1:0] exp_req_line = '0;

    // responder state
    logic [TAG_W-1:0]  rq_tag  [$];
    logic [LINE_W-1:0] rq_line [$];
    int                rq_cyc  [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BEAT_W-1:0] beat_pattern(input logic [LINE_W-1:0] ln, input int w);
        return {ln, 2'(w), 3'b101, 32'h5A5A_0000 + 32'(w)};
    endfunction

    // Lower-level model: one burst at a time, 4-1-1-1.
    initial begin
        int cyc = 0;
        bit active = 1'b0;
        int word = 0;
        logic [TAG_W-1:0]  cur_tag = '0;
        logic [LINE_W-1:0] cur_line = '0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            l2_beat_valid = 1'b0;
            if (!rst_n) continue;
            if (l2_req_valid) begin
                rq_tag.push_back(l2_req_tag);
                rq_line.push_back(l2_req_line);
                rq_cyc.push_back(cyc);
            end
            if (!active && rq_cyc.size() > 0 && cyc >= rq_cyc[0] + 4) begin
                active   = 1'b1;
                word     = 0;
                cur_tag  = rq_tag.pop_front();
                cur_line = rq_line.pop_front();
                void'(rq_cyc.pop_front());
            end
            if (active) begin
                l2_beat_valid = 1'b1;
                l2_beat_tag   = cur_tag;
                l2_beat_data  = beat_pattern(cur_line, word);
                word++;
                if (word == 4) active = 1'b0;
            end
        end
    end

    // Monitor: compares outputs against the scoreboard.
    initial begin
        bit                pv_wr = 1'b0;
        logic [CNT_W-1:0]  pv_word = '0;
        logic [LINE_W-1:0] pv_line = '0;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) continue;
            if (l1_wr_en || l2_beat_valid)
                chk(l1_wr_en == l2_beat_valid, "R3", "write one cycle after beat",
                    longint'(l1_wr_en), longint'(l2_beat_valid));
            if (l1_wr_en && l2_beat_valid) begin
                logic [LINE_W-1:0] ln;
                int nw;
                ln = tag_line[l2_beat_tag];
                nw = next_word.exists(ln) ? next_word[ln] : -1;
                chk(l1_wr_line == ln, "R3", "write line", longint'(l1_wr_line), longint'(ln));
                chk(int'(l1_wr_word) == nw, "R3", "word order", longint'(l1_wr_word), longint'(nw));
                chk(l1_wr_data == beat_pattern(ln, int'(l1_wr_word)), "R3", "write data",
                    longint'(l1_wr_data), longint'(beat_pattern(ln, int'(l1_wr_word))));
                if (next_word.exists(ln)) next_word[ln] = next_word[ln] + 1;
            end
            if (l1_line_valid) begin
                logic [LINE_W-1:0] el;
                el = (exp_done.size() > 0) ? exp_done.pop_front() : '1;
                chk(l1_valid_line == el, "R8", "completion order",
                    longint'(l1_valid_line), longint'(el));
                chk(pv_wr && pv_word == 2'd3 && pv_line == l1_valid_line, "R4",
                    "valid right after word 3", longint'(pv_word), 3);
                chk(next_word.exists(l1_valid_line) && next_word[l1_valid_line] == 4, "R4",
                    "all words written before valid",
                    next_word.exists(l1_valid_line) ? longint'(next_word[l1_valid_line]) : -1, 4);
                outst.delete(l1_valid_line);
                next_word.delete(l1_valid_line);
            end
            if (exp_req_pending) begin
                chk(l2_req_valid && l2_req_line == exp_req_line, "R2", "request after accept",
                    longint'(l2_req_line), longint'(exp_req_line));
                tag_line[l2_req_tag] = l2_req_line;
                exp_req_pending = 1'b0;
            end else if (l2_req_valid) begin
                chk(1'b0, "R5", "request without new allocation",
                    longint'(l2_req_line), 0);
            end
            pv_wr   = l1_wr_en;
            pv_word = l1_wr_word;
            pv_line = l1_wr_line;
        end
    end

    // Driver: presents one miss, retrying until accepted.
    task automatic present_miss(input logic [LINE_W-1:0] ln);
        bit accepted = 1'b0;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = ln;
        while (!accepted) begin
            bit merge;
            bit exp_rdy;
            #1;
            merge   = outst.exists(ln);
            exp_rdy = merge || (outst.num() < N_ENT);
            if (merge)
                chk(miss_ready == 1'b1, "R5", "merge accepted", longint'(miss_ready), 1);
            else if (outst.num() > 0 && exp_rdy)
                chk(miss_ready == 1'b1, "R7", "accept while fills outstanding",
                    longint'(miss_ready), 1);
            else
                chk(miss_ready == exp_rdy, "R6", "ready versus occupancy",
                    longint'(miss_ready), longint'(exp_rdy));
            @(posedge clk);
            if (miss_ready && exp_rdy) begin
                accepted = 1'b1;
                if (!merge) begin
                    outst[ln]     = 1;
                    next_word[ln] = 0;
                    exp_done.push_back(ln);
                    exp_req_pending = 1'b1;
                    exp_req_line    = ln;
                end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        miss_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_done.size() > 0 || outst.num() > 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk(miss_ready == 1'b1, "R1", "ready in reset", longint'(miss_ready), 1);
        chk(l2_req_valid == 1'b0, "R1", "no request in reset", longint'(l2_req_valid), 0);
        chk(l1_wr_en == 1'b0, "R1", "no write in reset", longint'(l1_wr_en), 0);
        chk(l1_line_valid == 1'b0, "R1", "no valid in reset", longint'(l1_line_valid), 0);
        rst_n = 1'b1;
        go_idle(2);

        // single fill
        present_miss(27'h0000100);
        go_idle(1);
        drain();

        // five distinct lines back to back: the fifth stalls (R6)
        for (int i = 0; i < 5; i++) present_miss(27'h0001000 + 27'(i));
        go_idle(1);
        drain();

        // merges, including one into a line that is finishing (R5)
        present_miss(27'h0000200);
        present_miss(27'h0000200);
        go_idle(3);
        present_miss(27'h0000200);
        present_miss(27'h0000201);
        go_idle(5);
        present_miss(27'h0000200);
        present_miss(27'h0000201);
        go_idle(1);
        drain();

        // pseudo-random misses over a small pool
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            present_miss(27'h0002000 + 27'(lfsr[2:0] % 6));
            if (lfsr[5:4] == 2'b00) go_idle(int'(lfsr[8:6]));
        end
        go_idle(1);
        drain();

        chk(exp_done.size() == 0, "R4", "every fill completed", longint'(exp_done.size()), 0);
        chk(outst.num() == 0, "R6", "all entries released", longint'(outst.num()), 0);
        repeat (10) @(negedge clk);
        chk(l2_req_valid == 1'b0 && l1_wr_en == 1'b0, "R5", "quiet after drain",
            longint'(l2_req_valid), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule